// File: doc/BRIEF.md
# Extended-Range Phase/Frequency Detector

This block compares rising edges of a sense signal against a reference signal and produces a three-level correction command. The command is carried as two enables: `pump_up_o` drives the level high, `pump_dn_o` drives it low, and with neither set the output sits at an undriven middle level. When the two frequencies are equal, the detector pulses up or down for the interval between the two edges. When one input runs persistently faster, the detector saturates in the matching direction.

The detector is a ten-position state chain. A sense edge moves the state one place toward the positive end and a reference edge moves it one place toward the negative end. The chain holds four phase-tracking positions, two crossover positions and four frequency-error positions. A slip flag goes low whenever the chain leaves the phase-tracking positions. Both inputs are synchronised into the system clock and edge-detected before they reach the state logic.

Top module: `xrange_pfd`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the state is negative-idle: `pump_up_o`=0, `pump_dn_o`=0 and `slip_n_o`=1.
- R2: `pump_up_o` and `pump_dn_o` are never 1 in the same cycle.
- R3: From either idle position, a sense edge sets `pump_up_o`=1. A following reference edge returns the output to the middle level (both enables 0).
- R4: From either idle position, a reference edge sets `pump_dn_o`=1. A following sense edge returns the output to the middle level.
- R5: A sense edge and a reference edge detected in the same clock cycle leave the state and all outputs unchanged.
- R6: Two sense edges from idle with no reference edge between them enter the positive crossover position. There `pump_up_o`=1 and `slip_n_o`=0. Further sense edges move through positive frequency error to the positive hold position, which holds on further sense edges.
- R7: The negative side mirrors R6. Two reference edges from idle enter negative crossover with `pump_dn_o`=1 and `slip_n_o`=0. The chain then saturates at negative hold.
- R8: `slip_n_o` is 1 only in the four phase-tracking positions: both idles, positive-active and negative-active. Whenever both enables are 0, `slip_n_o` is 1.
- R9: A rising edge on an input pin changes the outputs on the fourth rising clock edge after the pin is sampled high. This delay is made up of two synchroniser flops, a registered edge detect and the state register.
- R10: From a hold position, edges of the opposite kind step back one position at a time. The output stays saturated until the chain re-enters the phase-tracking positions.
- R11: A clock cycle with no detected edge leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| sense_i | input | 1 | Sense (+) input, asynchronous |
| ref_i | input | 1 | Reference (−) input, asynchronous |
| pump_up_o | output | 1 | Drive the output high |
| pump_dn_o | output | 1 | Drive the output low |
| slip_n_o | output | 1 | Active-low out-of-phase-range indicator |

## Verification
The checker watches every cycle for the following:
- the up and down enables are never set together;
- the middle level never coincides with a low slip flag;
- the state holds when no edge arrives or when two edges cancel;
- the chain saturates at both hold positions;
- a lone sense edge from idle raises the up enable.

The bench scenarios cover what needs a history of edges: the pulse shape in leading and lagging phase, the walk through crossover into frequency error and back down again, the exact four-cycle input-to-output delay, and recovery from a reset applied mid-run.

// File: rtl/xrange_pfd_pkg.sv
package xrange_pfd_pkg;
  localparam int unsigned POS_W = 4;

  // Chain positions: sense edges move upward, reference edges downward.
  typedef enum logic [POS_W-1:0] {
    P_NHOLD = 4'd0,
    P_NFREQ = 4'd1,
    P_NXOV  = 4'd2,
    P_NACT  = 4'd3,
    P_NIDLE = 4'd4,
    P_PIDLE = 4'd5,
    P_PACT  = 4'd6,
    P_PXOV  = 4'd7,
    P_PFREQ = 4'd8,
    P_PHOLD = 4'd9
  } pos_t;
endpackage

// File: rtl/xrange_rst_sync.sv
module xrange_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/xrange_edge_det.sv
module xrange_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      prev_q <= sync_q[SYNC_STAGES-1];
      rise_q <= sync_q[SYNC_STAGES-1] & ~prev_q;
    end
  end

  assign rise_o = rise_q;
endmodule

// File: rtl/xrange_chain_fsm.sv
module xrange_chain_fsm
  import xrange_pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic up_step_i,
  input  logic dn_step_i,
  output pos_t pos_o,
  output logic pump_up_o,
  output logic pump_dn_o,
  output logic slip_n_o
);
  pos_t             pos_q, pos_d;
  logic             step_en;
  logic [POS_W-1:0] pos_inc, pos_dec;

  assign pos_inc = pos_q + 4'd1;
  assign pos_dec = pos_q - 4'd1;
  // Coincident edges cancel, so only a lone edge enables the register.
  assign step_en = up_step_i ^ dn_step_i;

  always_comb begin
    pos_d = pos_q;
    if (up_step_i && !dn_step_i) begin
      if (pos_q == P_NIDLE)      pos_d = P_PACT;
      else if (pos_q != P_PHOLD) pos_d = pos_t'(pos_inc);
    end else if (dn_step_i && !up_step_i) begin
      if (pos_q == P_PIDLE)      pos_d = P_NACT;
      else if (pos_q != P_NHOLD) pos_d = pos_t'(pos_dec);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos_q <= P_NIDLE;
    else if (step_en) pos_q <= pos_d;
  end

  assign pos_o     = pos_q;
  assign pump_up_o = (pos_q >= P_PACT);
  assign pump_dn_o = (pos_q <= P_NACT);
  assign slip_n_o  = (pos_q >= P_NACT) && (pos_q <= P_PACT);
endmodule

// File: rtl/xrange_pfd.sv
module xrange_pfd
  import xrange_pfd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_i,
  input  logic ref_i,
  output logic pump_up_o,
  output logic pump_dn_o,
  output logic slip_n_o
);
  logic rst_sync_n;
  logic sense_rise, ref_rise;
  pos_t pos;

  xrange_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n)
  );

  xrange_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_sense_edge (
    .clk(clk), .rst_n(rst_sync_n), .pin_i(sense_i), .rise_o(sense_rise)
  );

  xrange_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_ref_edge (
    .clk(clk), .rst_n(rst_sync_n), .pin_i(ref_i), .rise_o(ref_rise)
  );

  xrange_chain_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .up_step_i(sense_rise), .dn_step_i(ref_rise),
    .pos_o(pos),
    .pump_up_o(pump_up_o), .pump_dn_o(pump_dn_o), .slip_n_o(slip_n_o)
  );
endmodule

// File: rtl/xrange_pfd_chk.sv
module xrange_pfd_chk
  import xrange_pfd_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic up_e,
  input logic dn_e,
  input pos_t pos,
  input logic up,
  input logic dn,
  input logic slip_n
);
  a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && dn));

  a_r8_middle_is_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!up && !dn) |-> slip_n);

  a_r5_cancel_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (up_e && dn_e) |=> $stable(pos));

  a_r11_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_e && !dn_e) |=> $stable(pos));

  a_r6_pos_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == P_PHOLD && up_e && !dn_e) |=> (pos == P_PHOLD));

  a_r7_neg_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == P_NHOLD && dn_e && !up_e) |=> (pos == P_NHOLD));

  a_r3_idle_up: assert property (@(posedge clk) disable iff (!rst_n)
    ((pos == P_NIDLE || pos == P_PIDLE) && up_e && !dn_e) |=> (up && !dn));

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pos == P_NIDLE));
endmodule

bind xrange_pfd xrange_pfd_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .up_e(sense_rise), .dn_e(ref_rise),
  .pos(pos), .up(pump_up_o), .dn(pump_dn_o), .slip_n(slip_n_o)
);

// File: tb/tb_xrange_pfd.sv
module tb_xrange_pfd;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sense_i = 1'b0;
  logic ref_i = 1'b0;
  logic up, dn, slip_n;

  always #2 clk = ~clk;

  xrange_pfd dut (
    .clk(clk), .rst_n(rst_n), .sense_i(sense_i), .ref_i(ref_i),
    .pump_up_o(up), .pump_dn_o(dn), .slip_n_o(slip_n)
  );

  typedef struct {
    logic  up;
    logic  dn;
    logic  slip_n;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // Monitor: compares one queued item per cycle, after the outputs settle.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (up !== e.up || dn !== e.dn || slip_n !== e.slip_n) begin
          n_fail++;
          $display("FAIL %s: got up=%b dn=%b slip_n=%b, expected up=%b dn=%b slip_n=%b",
                   e.tag, up, dn, slip_n, e.up, e.dn, e.slip_n);
        end
      end
    end
  end

  task automatic expect_out(input logic u, input logic d, input logic s, input string tag);
    exp_t e;
    e.up = u; e.dn = d; e.slip_n = s; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Driver: one pulse on either or both pins, then quiet until settled.
  task automatic pulse(input logic p, input logic m,
                       input logic u, input logic d, input logic s, input string tag);
    @(negedge clk);
    sense_i = p; ref_i = m;
    repeat (3) @(negedge clk);
    sense_i = 1'b0; ref_i = 1'b0;
    repeat (6) @(negedge clk);
    expect_out(u, d, s, tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_out(1'b0, 1'b0, 1'b1, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_out(1'b0, 1'b0, 1'b1, "R1 after release");
    @(negedge clk);

    // R9: latency. Raise sense at a negedge; outputs change after the 4th posedge.
    sense_i = 1'b1;
    expect_out(1'b0, 1'b0, 1'b1, "R9 cycle1 unchanged");
    @(negedge clk); expect_out(1'b0, 1'b0, 1'b1, "R9 cycle2 unchanged");
    @(negedge clk); expect_out(1'b0, 1'b0, 1'b1, "R9 cycle3 unchanged");
    @(negedge clk); expect_out(1'b1, 1'b0, 1'b1, "R9 cycle4 up");
    @(negedge clk); sense_i = 1'b0;
    repeat (6) @(negedge clk);
    expect_out(1'b1, 1'b0, 1'b1, "R11 up held while quiet");
    @(negedge clk);

    pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R3 ref edge ends up pulse");
    pulse(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R4 ref edge from idle, down");
    pulse(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R4 sense edge ends down pulse");
    pulse(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R5 coincident edges cancel at idle");
    pulse(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R3 sense from idle, up");
    pulse(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R5 coincident edges cancel while up");
    pulse(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6 crossover");
    pulse(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6 freq error");
    pulse(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6 hold");
    pulse(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6 hold saturates");
    pulse(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R10 step back to freq error");
    pulse(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R10 step back to crossover");
    pulse(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R10 back in positive active");
    pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R10 positive idle");
    pulse(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R4 from positive idle, down");
    pulse(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R7 crossover");
    pulse(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R7 freq error");
    pulse(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R7 hold");
    pulse(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R7 hold saturates");
    pulse(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R10 neg step back");
    pulse(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R10 neg crossover again");
    pulse(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R8 negative active locked");
    pulse(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8 negative idle locked");
    pulse(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R3 up again");
    pulse(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6 crossover before reset");

    // R1: asynchronous reset in mid-run returns to idle.
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); expect_out(1'b0, 1'b0, 1'b1, "R1 mid-run reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pulse(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R4 after reset, down");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule